// File: doc/BRIEF.md
# I2C Master Stop-Condition Generator with Collision Detection

This block ends an I2C transfer from the master side. When a stop is requested while the block is idle, it pulls SDA low and holds SCL low. Once SDA reads back low it releases SCL and waits for SCL to read high, which lets a slave stretch the clock. After the high level it holds the bus for one baud period, then releases SDA and checks that SDA really rises. Every timed phase comes from a down-counter loaded from a static 7-bit reload input.

Both bus lines are open-drain. Each is modelled as a pull-low enable output plus a sampled level input, and each level passes through a two-flop synchronizer. A clean stop gives a one-cycle completion pulse. The block gives up the stop and raises a sticky collision flag in two cases: another master keeps SDA low after SDA has been released, or SCL drops after it was seen high and before SDA has risen. A collision also releases both lines at once. The flag stays set until a one-cycle clear input is applied. If the clear arrives in the same cycle as a new collision, the collision wins.

Top module: `i2c_stop_gen`

## Requirements
- R1: After reset, neither line is pulled low, `stop_done` is 0 and `bus_coll` is 0.
- R2: A request accepted in idle pulls SDA and SCL low together. SCL is released only after SDA has been read back low, so SDA is low at the bus when SCL is let go.
- R3: While another device holds SCL low after its release (clock stretching), the block keeps SDA pulled low and waits without a time limit.
- R4: The baud period N is the 7-bit `reload` value, except that 0 counts as 1. With no collision, SDA is released exactly N+3 clock cycles after SCL rises at the bus. That is N cycles of hold plus 3 cycles of synchronizer and decision latency.
- R5: On a clean stop, `stop_done` is high for exactly one cycle. It rises N+2 cycles after SDA rises at the bus: one baud period plus a 2-cycle settle for the synchronizer.
- R6: If SDA still reads low when the final check is made after SDA is released, `bus_coll` sets, `stop_done` is not pulsed, and both pull-low outputs are 0.
- R7: If SCL reads low after it was seen high and before SDA has read high, `bus_coll` sets, `stop_done` is not pulsed, and both lines are released.
- R8: A `stop_go` request made while a stop is in progress is ignored. No second sequence starts after the current one ends.
- R9: `bus_coll` stays set until `coll_clear` is high for a cycle. A clear in the same cycle as a new collision leaves the flag set for one more cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stop_go | input | 1 | Stop request, sampled only when idle |
| reload | input | 7 | Baud period in cycles (0 treated as 1) |
| coll_clear | input | 1 | Single-cycle clear of the collision flag |
| sda_level | input | 1 | Level read from the SDA line |
| scl_level | input | 1 | Level read from the SCL line |
| sda_pull_low | output | 1 | Enable that pulls SDA low |
| scl_pull_low | output | 1 | Enable that pulls SCL low |
| stop_done | output | 1 | One-cycle pulse on a clean stop |
| bus_coll | output | 1 | Sticky collision flag |

## Verification
The stop sequence is run with three bus behaviours:
- A quiet bus pins down the exact hold and settle cycle counts against the reload value, including reload 0 and large reloads.
- A second master holding SDA low exercises the late-SDA collision and separates it from a clean stop.
- A second master pulling SCL low a random number of cycles after its rise exercises the early-SCL collision.

Random slave clock stretching is layered over all three to show that the hold period is counted only from the SCL rise. Directed cases add a request during a busy stop and a clear held across a collision.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int unsigned RELOAD_W    = 7;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_GRAB   = 3'd1,
    ST_SETUP  = 3'd2,
    ST_RELSCL = 3'd3,
    ST_HOLD   = 3'd4,
    ST_RELSDA = 3'd5,
    ST_SETTLE = 3'd6
  } stop_state_e;
endpackage

// File: rtl/i2cs_rst_sync.sv
module i2cs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_sync = hold_q;
endmodule

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '1;
        else        stage_q[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '1;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/i2cs_baud.sv
module i2cs_baud #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = (load_val == '0) ? ONE : load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == ONE);

  AST_CNT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load) |=> (cnt_q == '0)); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > ONE && !load) |=> (cnt_q == $past(cnt_q) - ONE)); // R4
  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q != '0)); // R4
endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
  import i2cs_pkg::*;
#(
  parameter int unsigned W      = RELOAD_W,
  parameter int unsigned SETTLE = SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop_go,
  input  logic [W-1:0] reload,
  input  logic         coll_clear,
  input  logic         s_sda,
  input  logic         s_scl,
  input  logic         baud_exp,
  output logic         baud_load,
  output logic [W-1:0] baud_val,
  output logic         sda_pull_low,
  output logic         scl_pull_low,
  output logic         stop_done,
  output logic         bus_coll
);
  localparam logic [W-1:0] SETTLE_LEN = W'(SETTLE);

  stop_state_e state_q, state_d;
  logic        sda_drv_q, sda_drv_d;
  logic        scl_drv_q, scl_drv_d;
  logic        done_q, done_d;
  logic        coll_q, coll_d;
  logic        coll_set;
  logic        use_settle;

  // next state
  always_comb begin
    state_d    = state_q;
    baud_load  = 1'b0;
    use_settle = 1'b0;
    coll_set   = 1'b0;
    done_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (stop_go) state_d = ST_GRAB;
      end
      ST_GRAB: begin
        if (!s_sda) begin
          state_d   = ST_SETUP;
          baud_load = 1'b1;
        end
      end
      ST_SETUP: begin
        if (baud_exp) state_d = ST_RELSCL;
      end
      ST_RELSCL: begin
        if (s_scl) begin
          state_d   = ST_HOLD;
          baud_load = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!s_scl) begin
          state_d  = ST_IDLE;
          coll_set = 1'b1;
        end else if (baud_exp) begin
          state_d   = ST_RELSDA;
          baud_load = 1'b1;
        end
      end
      ST_RELSDA: begin
        if (!s_scl && !s_sda) begin
          state_d  = ST_IDLE;
          coll_set = 1'b1;
        end else if (baud_exp) begin
          state_d    = ST_SETTLE;
          baud_load  = 1'b1;
          use_settle = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (!s_scl && !s_sda) begin
          state_d  = ST_IDLE;
          coll_set = 1'b1;
        end else if (baud_exp) begin
          state_d  = ST_IDLE;
          coll_set = !s_sda;
          done_d   = s_sda;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // pin drive derived from the next state, registered
  always_comb begin
    sda_drv_d = (state_d == ST_GRAB)   || (state_d == ST_SETUP) ||
                (state_d == ST_RELSCL) || (state_d == ST_HOLD);
    scl_drv_d = (state_d == ST_GRAB)   || (state_d == ST_SETUP);
    coll_d    = coll_set || (coll_q && !coll_clear);
  end

  assign baud_val = use_settle ? SETTLE_LEN : reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sda_drv_q <= 1'b0;
      scl_drv_q <= 1'b0;
      done_q    <= 1'b0;
      coll_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      sda_drv_q <= sda_drv_d;
      scl_drv_q <= scl_drv_d;
      done_q    <= done_d;
      coll_q    <= coll_d;
    end
  end

  assign sda_pull_low = sda_drv_q;
  assign scl_pull_low = scl_drv_q;
  assign stop_done    = done_q;
  assign bus_coll     = coll_q;

  AST_SCL_AFTER_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drv_q) |-> sda_drv_q); // R2
  AST_STRETCH_HOLDS_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RELSCL && !s_scl) |=> sda_drv_q); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R5
  AST_NO_DONE_ON_COLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll_q) |-> !done_q); // R6
  AST_COLL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll_q) |-> (!sda_drv_q && !scl_drv_q)); // R7
  AST_BUSY_IGNORES_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && stop_go && s_scl && !baud_exp) |=> (state_q == ST_HOLD)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_q && !coll_clear) |=> coll_q); // R9
endmodule

// File: rtl/i2c_stop_gen.sv
module i2c_stop_gen
  import i2cs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop_go,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                coll_clear,
  input  logic                sda_level,
  input  logic                scl_level,
  output logic                sda_pull_low,
  output logic                scl_pull_low,
  output logic                stop_done,
  output logic                bus_coll
);
  logic                rst_n_int;
  logic [1:0]          lines_s;
  logic                baud_load;
  logic [RELOAD_W-1:0] baud_val;
  logic                baud_exp;

  i2cs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  i2cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d     ({sda_level, scl_level}),
    .q     (lines_s)
  );

  i2cs_baud #(.W(RELOAD_W)) u_baud (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (baud_load),
    .load_val (baud_val),
    .expired  (baud_exp)
  );

  i2cs_fsm #(.W(RELOAD_W), .SETTLE(SYNC_STAGES)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .stop_go      (stop_go),
    .reload       (reload),
    .coll_clear   (coll_clear),
    .s_sda        (lines_s[1]),
    .s_scl        (lines_s[0]),
    .baud_exp     (baud_exp),
    .baud_load    (baud_load),
    .baud_val     (baud_val),
    .sda_pull_low (sda_pull_low),
    .scl_pull_low (scl_pull_low),
    .stop_done    (stop_done),
    .bus_coll     (bus_coll)
  );
endmodule

// File: tb/test_i2c_stop_gen.sv
module test_i2c_stop_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_go = 1'b0;
  logic [6:0] reload = 7'd4;
  logic       coll_clear = 1'b0;
  logic       sda_pull_low, scl_pull_low, stop_done, bus_coll;
  logic       tb_sda_low = 1'b0;
  logic       tb_scl_low = 1'b0;
  logic       meas_rst = 1'b1;
  wire        sda_bus = !(sda_pull_low || tb_sda_low);
  wire        scl_bus = !(scl_pull_low || tb_scl_low);

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int hold_cnt, tail_cnt, done_hi, coll_hi;
  logic done_seen;

  always #2.5 clk = !clk;

  i2c_stop_gen i_i2c_stop_gen (
    .clk(clk), .rst_n(rst_n), .stop_go(stop_go), .reload(reload),
    .coll_clear(coll_clear), .sda_level(sda_bus), .scl_level(scl_bus),
    .sda_pull_low(sda_pull_low), .scl_pull_low(scl_pull_low),
    .stop_done(stop_done), .bus_coll(bus_coll)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // bus-level measurement at the inactive edge
  always @(negedge clk) begin
    if (meas_rst) begin
      hold_cnt = 0; tail_cnt = 0; done_hi = 0; coll_hi = 0; done_seen = 1'b0;
    end else begin
      if (scl_bus && !sda_bus) hold_cnt++;
      if (stop_done) begin
        done_hi++;
        done_seen = 1'b1;
      end else if (hold_cnt > 0 && sda_bus && !done_seen) begin
        tail_cnt++;
      end
      if (bus_coll) coll_hi++;
    end
  end

  function automatic int exp_period(input int rl);
    return (rl == 0) ? 1 : rl;
  endfunction
  function automatic int exp_hold(input int rl);
    return exp_period(rl) + 3;
  endfunction
  function automatic int exp_tail(input int rl);
    return exp_period(rl) + 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // mode 0: clean, 1: other master keeps SDA low, 2: other master pulls SCL low
  task automatic run_stop(input int rl, input int stretch, input int mode,
                          input int k, input bit clr_hold);
    bit got_done, got_coll;
    meas_rst = 1'b1; tb_sda_low = 1'b0; tb_scl_low = 1'b0;
    tick();
    meas_rst = 1'b0;
    reload = 7'(rl);
    coll_clear = clr_hold;
    stop_go = 1'b1;
    if (mode == 1) tb_sda_low = 1'b1;
    if (stretch > 0) tb_scl_low = 1'b1;
    tick();
    stop_go = 1'b0;
    for (int i = 0; i < 2000 && !scl_pull_low; i++) tick();
    for (int i = 0; i < 2000 && scl_pull_low; i++) tick();
    check(!sda_bus, "R2 SDA at SCL release", int'(sda_bus), 0);
    if (stretch > 0) begin
      for (int i = 0; i < stretch; i++) begin
        check(sda_pull_low && !scl_bus, "R3 SDA held while stretched",
              int'(sda_pull_low), 1);
        tick();
      end
      tb_scl_low = 1'b0;
    end
    if (mode == 0) begin
      tick();
      stop_go = 1'b1;                // R8: request while busy
      tick();
      stop_go = 1'b0;
    end
    if (mode == 2) begin
      for (int i = 0; i < k; i++) tick();
      tb_scl_low = 1'b1;
    end
    got_done = 1'b0; got_coll = 1'b0;
    for (int i = 0; i < 3000 && !got_done && !got_coll; i++) begin
      tick();
      got_done = stop_done;
      got_coll = bus_coll;
    end
    repeat (4) tick();
    if (mode == 0) begin
      check(got_done && !bus_coll, "R5 clean stop completes", int'(got_done), 1);
      check(hold_cnt == exp_hold(rl), "R4 hold cycles", hold_cnt, exp_hold(rl));
      check(tail_cnt == exp_tail(rl), "R5 done delay", tail_cnt, exp_tail(rl));
      check(done_hi == 1, "R5 done width", done_hi, 1);
      repeat (6) tick();
      check(!sda_pull_low && !scl_pull_low, "R8 busy request ignored",
            int'(sda_pull_low || scl_pull_low), 0);
    end else begin
      string rq;
      rq = (mode == 1) ? "R6 collision" : "R7 collision";
      check(got_coll && done_hi == 0, rq, int'(got_coll), 1);
      check(!sda_pull_low && !scl_pull_low, rq,
            int'(sda_pull_low || scl_pull_low), 0);
      if (clr_hold) begin
        check(coll_hi == 1, "R9 set wins over clear", coll_hi, 1);
      end else begin
        check(bus_coll, "R9 flag sticky", int'(bus_coll), 1);
      end
    end
    tb_sda_low = 1'b0; tb_scl_low = 1'b0;
    coll_clear = 1'b1;
    tick();
    coll_clear = 1'b0;
    tick();
    check(!bus_coll, "R9 clear", int'(bus_coll), 0);
  endtask

  initial begin
    void'($urandom(32'h1D5C0));
    #1;
    check(!sda_pull_low && !scl_pull_low && !stop_done && !bus_coll,
          "R1 in reset", int'(sda_pull_low), 0);
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (5) tick();
    check(!sda_pull_low && !scl_pull_low && !stop_done && !bus_coll,
          "R1 after reset", int'(bus_coll), 0);

    // directed corners
    run_stop(4, 0, 0, 0, 1'b0);
    run_stop(0, 0, 0, 0, 1'b0);     // R4 reload 0 -> period 1
    run_stop(1, 0, 0, 0, 1'b0);
    run_stop(127, 0, 0, 0, 1'b0);
    run_stop(5, 7, 0, 0, 1'b0);     // R3 stretched clean stop
    run_stop(3, 0, 1, 0, 1'b0);     // R6
    run_stop(6, 0, 2, 1, 1'b0);     // R7 early
    run_stop(6, 2, 2, 6, 1'b0);     // R7 late, stretched
    run_stop(4, 0, 1, 0, 1'b1);     // R9 clear held across collision

    // random mix
    for (int n = 0; n < 40; n++) begin
      int rl, st, md, kk;
      rl = ($urandom % 8 == 0) ? 64 + int'($urandom % 64) : int'($urandom % 12);
      st = ($urandom % 2 == 0) ? 0 : 1 + int'($urandom % 6);
      md = int'($urandom % 3);
      kk = 1 + int'($urandom % exp_period(rl));
      run_stop(rl, st, md, kk, 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule